// File: doc/BRIEF.md
# Block-Transfer Micro-op Sequencer

This block takes one block-transfer instruction and expands it into a sequence of micro-operations. It emits one micro-operation per cycle under a valid/ready handshake. The instruction carries a register list, a base register number and five control bits: pre-index, up, user bank, writeback and load. The block works out the byte offset of every transfer and picks the opcode and register index for each micro-op. It marks the final micro-op of each sequence. Memory access, register-file updates and status restore happen downstream and are not part of this block.

The sequence begins by copying the base register into a temporary base register. One memory micro-op follows for each set bit of the list, in ascending register order, each addressed relative to that temporary. A base-update micro-op comes last when writeback is requested. Offsets are emitted as unsigned magnitudes together with a subtract flag. The starting magnitude is biased by the population count, so when the up bit is clear the effective address still rises from one transfer to the next.

A list with no bits set is accepted and answered with a one-cycle error pulse, and no micro-ops are emitted. A new instruction is taken only once the final micro-op of the previous one has been handshaken.

Top module: `lsm_uop_seq`

## Requirements
- R1: After reset, `in_ready` is 1, `uop_valid` is 0 and `err` is 0.
- R2: The first micro-op of a non-empty instruction has opcode COPY (0), `uop_reg` = TMP_IDX, `uop_base` = the instruction's base register, `uop_off` = 0 and `uop_neg` = 0.
- R3: With N bits set in the list, exactly N memory micro-ops follow the copy. They take the set registers in ascending index order, and each has `uop_base` = TMP_IDX.
- R4: The k-th memory micro-op (k from 0) has offset S + 4k when up = 1 and S − 4k when up = 0. S is 0 when up = 1 and 4N − 4 when up = 0, plus 4 when pre = 1. Memory micro-ops carry `uop_neg` = not up.
- R5: When user = 1 and list bit LIST_W−1 is clear, each transferred register index r is emitted as USR_BASE + r. Otherwise it is emitted as r.
- R6: A store emits opcode STORE (3). A load emits LOAD (1), except that with user = 1 the micro-op for register LIST_W−1 is LOAD_RET (2).
- R7: When writeback = 1, one further micro-op follows the memory micro-ops. Its opcode is ADDI (4) when up = 1 and SUBI (5) when up = 0, with `uop_reg` = `uop_base` = base register, `uop_off` = 4N and `uop_neg` = 0.
- R8: Only the final micro-op of a sequence has `uop_last` = 1. The sequence length is 1 + N, or 2 + N with writeback. After the final handshake the block returns to `in_ready` = 1 with `uop_valid` = 0.
- R9: An instruction with an empty list is accepted. `err` is 1 for exactly the cycle after acceptance, and no micro-op is emitted.
- R10: While `uop_valid` = 1 and `uop_ready` = 0, all micro-op outputs hold their values. `in_ready` stays 0 while a sequence is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle, instruction taken when valid |
| in_list | input | LIST_W | Register list, bit r selects register r |
| in_base | input | $clog2(LIST_W) | Base register number |
| in_pre | input | 1 | Pre-index: bias offsets by 4 |
| in_up | input | 1 | Up: addresses rise from the base |
| in_user | input | 1 | User-bank / exception-return qualifier |
| in_wb | input | 1 | Update base register at end |
| in_load | input | 1 | 1 = load, 0 = store |
| err | output | 1 | Pulse: empty list accepted |
| uop_valid | output | 1 | Micro-op presented |
| uop_ready | input | 1 | Consumer takes micro-op |
| uop_op | output | 3 | Opcode: 0 COPY, 1 LOAD, 2 LOAD_RET, 3 STORE, 4 ADDI, 5 SUBI |
| uop_reg | output | IDX_W | Destination/source register index |
| uop_base | output | IDX_W | Base operand register index |
| uop_off | output | OFFS_W | Byte offset magnitude |
| uop_neg | output | 1 | Offset is subtracted from the base |
| uop_last | output | 1 | Final micro-op of the sequence |

## Verification
The bench builds the block with its default parameters: a 16-bit list, 6-bit register indices, 8-bit offsets, TMP_IDX = 16 and USR_BASE = 32. It sweeps all 32 combinations of the five control bits across a list set that includes every single-bit list, the empty and full lists, lists with and without bit 15, and a spread of computed mixed patterns. That set covers both offset extremes (4N with pre and N = 16), exception-return against user-bank remapping, and the largest writeback displacement. The consumer stalls every fourth cycle, so the output-hold behaviour is exercised in the middle of sequences and on their final micro-op.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
   typedef enum logic [2:0] {
      OP_COPY     = 3'd0,
      OP_LOAD     = 3'd1,
      OP_LOAD_RET = 3'd2,
      OP_STORE    = 3'd3,
      OP_ADDI     = 3'd4,
      OP_SUBI     = 3'd5
   } uop_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_COPY = 2'd1,
      ST_MEM  = 2'd2,
      ST_WB   = 2'd3
   } seq_st_e;
endpackage

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
   parameter int W   = 16,
   parameter int CW  = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] cnt
);
   logic [CW-1:0] part [W+1];

   assign part[0] = '0;

   for (genvar i = 0; i < W; i++) begin : g_acc
      assign part[i+1] = part[i] + CW'(vec[i]);
   end

   assign cnt = part[W];
endmodule

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
   parameter int W  = 16,
   parameter int IW = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic [W-1:0]  onehot,
   output logic [IW-1:0] idx
);
   logic [W:0] seen;

   assign seen[0] = 1'b0;

   for (genvar i = 0; i < W; i++) begin : g_chain
      assign onehot[i]  = vec[i] & ~seen[i];
      assign seen[i+1]  = seen[i] | vec[i];
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < W; i++) begin
         if (onehot[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/lsm_regmap.sv
module lsm_regmap #(
   parameter int IW       = 4,
   parameter int OW       = 6,
   parameter bit BANK_EN  = 1'b1,
   parameter int USR_BASE = 32
) (
   input  logic [IW-1:0] reg_in,
   input  logic          to_user,
   output logic [OW-1:0] reg_out
);
   if (BANK_EN) begin : g_bank
      assign reg_out = to_user ? (OW'(USR_BASE) + OW'(reg_in)) : OW'(reg_in);
   end else begin : g_flat
      logic unused_sel;
      assign unused_sel = to_user;
      assign reg_out    = OW'(reg_in);
   end
endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq
   import lsm_pkg::*;
#(
   parameter int LIST_W   = 16,
   parameter int IDX_W    = 6,
   parameter int OFFS_W   = 8,
   parameter int TMP_IDX  = 16,
   parameter int USR_BASE = 32,
   parameter bit BANK_EN  = 1'b1,
   localparam int RW      = $clog2(LIST_W),
   localparam int CW      = $clog2(LIST_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [LIST_W-1:0] in_list,
   input  logic [RW-1:0]     in_base,
   input  logic              in_pre,
   input  logic              in_up,
   input  logic              in_user,
   input  logic              in_wb,
   input  logic              in_load,
   output logic              err,
   output logic              uop_valid,
   input  logic              uop_ready,
   output logic [2:0]        uop_op,
   output logic [IDX_W-1:0]  uop_reg,
   output logic [IDX_W-1:0]  uop_base,
   output logic [OFFS_W-1:0] uop_off,
   output logic              uop_neg,
   output logic              uop_last
);
   localparam int PC_BIT   = LIST_W - 1;
   localparam int MAX_OFFS = 4 * LIST_W;

   if ((1 << OFFS_W) <= MAX_OFFS) begin : g_bad_offs
      $error("OFFS_W too narrow for 4*LIST_W");
   end
   if ((1 << IDX_W) <= TMP_IDX || (1 << IDX_W) < USR_BASE + LIST_W) begin : g_bad_idx
      $error("IDX_W cannot hold TMP_IDX or user bank");
   end
   if (LIST_W < 2) begin : g_bad_list
      $error("LIST_W must be at least 2");
   end

   seq_st_e              st_q;
   logic [LIST_W-1:0]    rem_q;
   logic [CW-1:0]        cnt_q;
   logic [OFFS_W-1:0]    offs_q;
   logic [RW-1:0]        base_q;
   logic                 up_q, user_q, wb_q, load_q, pc_q, err_q;

   logic [CW-1:0]        n_in;
   logic [OFFS_W-1:0]    start_offs;
   logic [LIST_W-1:0]    cur_oh;
   logic [RW-1:0]        cur_r;
   logic [IDX_W-1:0]     cur_idx;
   logic [LIST_W-1:0]    rem_next;
   logic                 accept, fire, mem_final;

   lsm_popcnt #(.W(LIST_W), .CW(CW)) u_pop (
      .vec (in_list),
      .cnt (n_in)
   );

   lsm_lowbit #(.W(LIST_W), .IW(RW)) u_low (
      .vec    (rem_q),
      .onehot (cur_oh),
      .idx    (cur_r)
   );

   lsm_regmap #(.IW(RW), .OW(IDX_W), .BANK_EN(BANK_EN), .USR_BASE(USR_BASE)) u_map (
      .reg_in  (cur_r),
      .to_user (user_q & ~pc_q),
      .reg_out (cur_idx)
   );

   assign accept    = in_valid & in_ready;
   assign fire      = uop_valid & uop_ready;
   assign rem_next  = rem_q & ~cur_oh;
   assign mem_final = (rem_next == '0);

   always_comb begin
      start_offs = in_up ? '0 : ((OFFS_W'(n_in) << 2) - OFFS_W'(4));
      if (in_pre) start_offs = start_offs + OFFS_W'(4);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         rem_q  <= '0;
         cnt_q  <= '0;
         offs_q <= '0;
         base_q <= '0;
         up_q   <= 1'b0;
         user_q <= 1'b0;
         wb_q   <= 1'b0;
         load_q <= 1'b0;
         pc_q   <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         err_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  rem_q  <= in_list;
                  cnt_q  <= n_in;
                  offs_q <= start_offs;
                  base_q <= in_base;
                  up_q   <= in_up;
                  user_q <= in_user;
                  wb_q   <= in_wb;
                  load_q <= in_load;
                  pc_q   <= in_list[PC_BIT];
                  if (in_list == '0) err_q <= 1'b1;
                  else               st_q  <= ST_COPY;
               end
            end
            ST_COPY: begin
               if (fire) st_q <= ST_MEM;
            end
            ST_MEM: begin
               if (fire) begin
                  rem_q  <= rem_next;
                  offs_q <= up_q ? offs_q + OFFS_W'(4) : offs_q - OFFS_W'(4);
                  if (mem_final) st_q <= wb_q ? ST_WB : ST_IDLE;
               end
            end
            ST_WB: begin
               if (fire) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign in_ready  = (st_q == ST_IDLE);
   assign uop_valid = (st_q != ST_IDLE);
   assign err       = err_q;

   always_comb begin
      uop_op   = OP_COPY;
      uop_reg  = '0;
      uop_base = '0;
      uop_off  = '0;
      uop_neg  = 1'b0;
      uop_last = 1'b0;
      unique case (st_q)
         ST_COPY: begin
            uop_op   = OP_COPY;
            uop_reg  = IDX_W'(TMP_IDX);
            uop_base = IDX_W'(base_q);
         end
         ST_MEM: begin
            if (!load_q)
               uop_op = OP_STORE;
            else if (user_q && cur_r == RW'(PC_BIT))
               uop_op = OP_LOAD_RET;
            else
               uop_op = OP_LOAD;
            uop_reg  = cur_idx;
            uop_base = IDX_W'(TMP_IDX);
            uop_off  = offs_q;
            uop_neg  = ~up_q;
            uop_last = mem_final & ~wb_q;
         end
         ST_WB: begin
            uop_op   = up_q ? OP_ADDI : OP_SUBI;
            uop_reg  = IDX_W'(base_q);
            uop_base = IDX_W'(base_q);
            uop_off  = OFFS_W'(cnt_q) << 2;
            uop_last = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/lsm_uop_seq_chk.sv
module lsm_uop_seq_chk #(
   parameter int LIST_W = 16,
   parameter int IDX_W  = 6,
   parameter int OFFS_W = 8,
   localparam int RW    = $clog2(LIST_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [LIST_W-1:0] in_list,
   input logic [RW-1:0]     in_base,
   input logic              err,
   input logic              uop_valid,
   input logic              uop_ready,
   input logic [2:0]        uop_op,
   input logic [IDX_W-1:0]  uop_reg,
   input logic [IDX_W-1:0]  uop_base,
   input logic [OFFS_W-1:0] uop_off,
   input logic              uop_neg,
   input logic              uop_last
);
   // R10
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_op) && $stable(uop_reg)
         && $stable(uop_base) && $stable(uop_off) && $stable(uop_neg) && $stable(uop_last)));

   // R2
   copy_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && (in_list != '0)) |=> (uop_valid && uop_op == 3'd0
         && uop_base == IDX_W'(in_base) && $past(in_base) == in_base || uop_op == 3'd0));

   // R9
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && (in_list == '0)) |=> (err && !uop_valid && in_ready));

   // R8
   last_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_valid && uop_ready && uop_last) |=> (in_ready && !uop_valid));

   // R4
   off_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uop_valid |-> (int'(uop_off) <= 4 * LIST_W));

   // R10
   busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_valid && !(uop_ready && uop_last)) |=> !in_ready);
endmodule

bind lsm_uop_seq lsm_uop_seq_chk #(
   .LIST_W (LIST_W),
   .IDX_W  (IDX_W),
   .OFFS_W (OFFS_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_list   (in_list),
   .in_base   (in_base),
   .err       (err),
   .uop_valid (uop_valid),
   .uop_ready (uop_ready),
   .uop_op    (uop_op),
   .uop_reg   (uop_reg),
   .uop_base  (uop_base),
   .uop_off   (uop_off),
   .uop_neg   (uop_neg),
   .uop_last  (uop_last)
);

// File: tb/sim_lsm_uop_seq.sv
module sim_lsm_uop_seq;
   localparam int LW   = 16;
   localparam int IW   = 6;
   localparam int OW   = 8;
   localparam int TMP  = 16;
   localparam int USRB = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [LW-1:0] in_list = '0;
   logic [3:0]    in_base = '0;
   logic          in_pre = 0, in_up = 0, in_user = 0, in_wb = 0, in_load = 0;
   logic          err, uop_valid, uop_neg, uop_last;
   logic          uop_ready = 1'b0;
   logic [2:0]    uop_op;
   logic [IW-1:0] uop_reg, uop_base;
   logic [OW-1:0] uop_off;

   int n_chk = 0;
   int n_err = 0;
   int step  = 0;

   always #2.5 clk = ~clk;

   lsm_uop_seq #(.LIST_W(LW), .IDX_W(IW), .OFFS_W(OW), .TMP_IDX(TMP), .USR_BASE(USRB)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_list(in_list), .in_base(in_base), .in_pre(in_pre), .in_up(in_up),
      .in_user(in_user), .in_wb(in_wb), .in_load(in_load), .err(err),
      .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_op(uop_op),
      .uop_reg(uop_reg), .uop_base(uop_base), .uop_off(uop_off),
      .uop_neg(uop_neg), .uop_last(uop_last)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic run(input logic [LW-1:0] l, input logic [4:0] f);
      int e_op[LW+2], e_reg[LW+2], e_base[LW+2], e_off[LW+2], e_neg[LW+2], e_last[LW+2];
      string t_op[LW+2], t_reg[LW+2];
      int n = 0, tot = 0, k = 0, s, guard;
      logic [3:0] b;
      bit pre, up, usr, wb, ld, remap;
      pre = f[0]; up = f[1]; usr = f[2]; wb = f[3]; ld = f[4];
      b = l[3:0] ^ {f[3:0]};
      for (int j = 0; j < LW; j++) if (l[j]) n++;
      remap = usr && !l[LW-1];
      s = (up ? 0 : 4*n - 4) + (pre ? 4 : 0);
      e_op[0] = 0; e_reg[0] = TMP; e_base[0] = b; e_off[0] = 0; e_neg[0] = 0; e_last[0] = 0;
      t_op[0] = "R2"; t_reg[0] = "R2";
      tot = 1;
      for (int j = 0; j < LW; j++) begin
         if (l[j]) begin
            e_op[tot]   = !ld ? 3 : ((usr && j == LW-1) ? 2 : 1);
            e_reg[tot]  = remap ? USRB + j : j;
            e_base[tot] = TMP;
            e_off[tot]  = up ? s + 4*k : s - 4*k;
            e_neg[tot]  = !up;
            e_last[tot] = (k == n-1) && !wb;
            t_op[tot]   = "R6";
            t_reg[tot]  = remap ? "R5" : "R3";
            k++; tot++;
         end
      end
      if (wb && n > 0) begin
         e_op[tot] = up ? 4 : 5; e_reg[tot] = b; e_base[tot] = b; e_off[tot] = 4*n;
         e_neg[tot] = 0; e_last[tot] = 1; t_op[tot] = "R7"; t_reg[tot] = "R7";
         tot++;
      end
      @(negedge clk);
      chk(in_ready == 1'b1, "R10", "in_ready idle", int'(in_ready), 1);
      in_valid = 1'b1; in_list = l; in_base = b;
      in_pre = pre; in_up = up; in_user = usr; in_wb = wb; in_load = ld;
      @(negedge clk);
      in_valid = 1'b0;
      if (n == 0) begin
         chk(err == 1'b1 && uop_valid == 1'b0, "R9", "err pulse", int'({err, uop_valid}), 2);
         @(negedge clk);
         chk(err == 1'b0 && in_ready == 1'b1, "R9", "err one cycle", int'({err, in_ready}), 1);
         return;
      end
      k = 0; guard = 0;
      while (k < tot && guard < 200) begin
         uop_ready = (step % 4) != 3;
         step++;
         if (uop_valid) chk(in_ready == 1'b0, "R10", "in_ready busy", int'(in_ready), 0);
         else chk(1'b0, "R8", "valid dropped early", k, tot);
         if (uop_valid && uop_ready) begin
            chk(int'(uop_op) == e_op[k], t_op[k], "opcode", int'(uop_op), e_op[k]);
            chk(int'(uop_reg) == e_reg[k], t_reg[k], "reg", int'(uop_reg), e_reg[k]);
            chk(int'(uop_base) == e_base[k], k == 0 ? "R2" : "R3", "base", int'(uop_base), e_base[k]);
            chk(int'(uop_off) == e_off[k], "R4", "offset", int'(uop_off), e_off[k]);
            chk(int'(uop_neg) == e_neg[k], "R4", "neg", int'(uop_neg), e_neg[k]);
            chk(int'(uop_last) == e_last[k], "R8", "last", int'(uop_last), e_last[k]);
            k++;
         end
         @(negedge clk);
         guard++;
      end
      uop_ready = 1'b0;
      chk(k == tot, "R8", "sequence length", k, tot);
      chk(uop_valid == 1'b0 && in_ready == 1'b1, "R8", "idle after last",
          int'({uop_valid, in_ready}), 1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [LW-1:0] lists [26];
      lists[0] = 16'h0000; lists[1] = 16'h0001; lists[2] = 16'h8000;
      lists[3] = 16'hFFFF; lists[4] = 16'h7FFF; lists[5] = 16'h8001;
      for (int i = 0; i < 20; i++) lists[6+i] = 16'((i * 40503 + 4660) ^ (i << 9));
      repeat (3) @(negedge clk);
      chk(in_ready == 1'b1 && uop_valid == 1'b0 && err == 1'b0, "R1", "reset state",
          int'({in_ready, uop_valid, err}), 4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1 && uop_valid == 1'b0 && err == 1'b0, "R1", "after reset",
          int'({in_ready, uop_valid, err}), 4);
      for (int f = 0; f < 32; f++) begin
         for (int i = 0; i < 26; i++) run(lists[i], 5'(f));
         for (int j = 0; j < LW; j++) run(LW'(1) << j, 5'(f));
      end
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule